// File: doc/BRIEF.md
# Voting trip logic with pulse self-test

The block watches N trip parameters, each delivered as three redundant channel bits. A channel bit of 1 means healthy and a bit of 0 means that channel demands a trip, so a broken wire reads as a trip. Each parameter gets its own two-out-of-three vote. An active-high holding output stays energized while no parameter votes to trip. It drops to 0 one clock after any parameter does, which releases every held rod together.

A built-in test engine checks the voting logic while the plant runs. It forces channels low in short pulses on a second, identical voter bank. For each parameter in turn it forces every single channel and then every channel pair. It samples that parameter's voted result at the end of each pulse. A single channel that trips on its own is reported as a safe failure. A pair that fails to trip is reported as a dangerous failure. The forced response appears only on a separate monitor output and never reaches the holding output.

Sweeps repeat after a programmable idle interval. A genuine trip aborts a sweep in progress, and the sweep starts again from its beginning once the trip clears.

Top module: `trip_vote_fit`

## Requirements
- R1: Parameter p uses bits chan_i[3p], chan_i[3p+1] and chan_i[3p+2] as channels 0, 1 and 2. The parameter votes to trip when at least two of its three bits are 0.
- R2: After each clock edge, hold_o is 1 exactly when no parameter's vote on the real chan_i, as present at that edge, indicates a trip. hold_o is 0 during reset.
- R3: Test forcing never changes hold_o. With healthy channels, hold_o stays 1 through every sweep.
- R4: A sweep lasts exactly N_PARAM*6*PULSE_W cycles, and test_act_o is 1 throughout it. Parameters are visited from 0 upward. Each parameter gets six steps of PULSE_W cycles each, in this order: channel 0 alone, channel 1 alone, channel 2 alone, then the pairs {0,1}, {1,2} and {0,2}.
- R5: test_trip_o is the OR of the votes on the forced channels, registered. In a cycle that follows an idle cycle (test_act_o was 0), it equals the real vote.
- R6: If a single-channel step ends with that parameter voting to trip, safe_fail_o is set.
- R7: If a pair step ends with that parameter not voting to trip, danger_fail_o is set. A correct design never sets it.
- R8: Both failure flags stay set until clr_i is high at a clock edge, and after that edge they read 0.
- R9: pass_cnt_o increments by one at the end of each complete sweep that had no failing step. Otherwise it keeps its value.
- R10: When a real trip appears at the input, test_act_o is 0 from the second clock edge onward and stays 0 while the trip lasts. Two edges after the trip clears, a new sweep starts from parameter 0, step 0.
- R11: Between two sweeps, test_act_o stays 0 for exactly interval_i+1 cycles. The value used is the one interval_i holds at the end of the previous sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_i | input | 3*N_PARAM | Redundant channel bits, 1 means healthy |
| interval_i | input | INTERVAL_W | Idle cycles between sweeps, minus one |
| clr_i | input | 1 | Synchronous clear of the failure flags |
| hold_o | output | 1 | Holding output, 1 means energized |
| test_trip_o | output | 1 | Monitor net carrying the voted response of the forced path |
| test_act_o | output | 1 | A test sweep is running |
| safe_fail_o | output | 1 | Sticky flag for a safe failure |
| danger_fail_o | output | 1 | Sticky flag for a dangerous failure |
| pass_cnt_o | output | PASS_W | Count of clean, complete sweeps |

## Verification
The bench stretches a real trip across the middle of a sweep and then releases it. A design that resumed the sweep or counted it as passed would show a short sweep, or a pass count one too high. One real channel is held low through a whole sweep. A correct design raises the safe flag, keeps the output energized and withholds the pass increment. A design that let a single channel trip the output, or that credited the sweep anyway, is caught there. The bench also measures sweep length and idle gap to the cycle, and it compares hold_o on every cycle under random channel patterns. Forcing that leaked into the holding path, off-by-one pulse or interval counters, and a vote that treats one low channel as a trip all show up as mismatches.

// File: rtl/tvf_pkg.sv
package tvf_pkg;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_RUN, SEQ_HOLD} seq_state_e;

  localparam int unsigned STEPS = 6;

  // forced-low channel set for a step: singles first, then pairs
  function automatic logic [2:0] step_mask(input logic [2:0] step);
    case (step)
      3'd0:    return 3'b001;
      3'd1:    return 3'b010;
      3'd2:    return 3'b100;
      3'd3:    return 3'b011;
      3'd4:    return 3'b110;
      default: return 3'b101;
    endcase
  endfunction

  function automatic logic step_is_pair(input logic [2:0] step);
    return step >= 3'd3;
  endfunction
endpackage

// File: rtl/tvf_vote_bank.sv
module tvf_vote_bank #(
  parameter int unsigned N_PARAM = 4
) (
  input  logic [3*N_PARAM-1:0] chan_i,
  output logic [N_PARAM-1:0]   vote_o
);
  for (genvar p = 0; p < N_PARAM; p++) begin : g_vote
    logic c0, c1, c2;
    assign c0 = chan_i[3*p];
    assign c1 = chan_i[3*p+1];
    assign c2 = chan_i[3*p+2];
    // 0 = trip demand; trip on any two lows
    assign vote_o[p] = (~c0 & ~c1) | (~c1 & ~c2) | (~c0 & ~c2);
  end
endmodule

// File: rtl/tvf_seq.sv
module tvf_seq
  import tvf_pkg::*;
#(
  parameter int unsigned N_PARAM    = 4,
  parameter int unsigned PULSE_W    = 4,
  parameter int unsigned INTERVAL_W = 16,
  parameter int unsigned PASS_W     = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [INTERVAL_W-1:0]   interval_i,
  input  logic                    clr_i,
  input  logic                    trip_i,
  input  logic [N_PARAM-1:0]      vote_i,
  output logic [3*N_PARAM-1:0]    force_mask_o,
  output logic                    act_o,
  output logic                    safe_fail_o,
  output logic                    danger_fail_o,
  output logic [PASS_W-1:0]       pass_cnt_o
);
  localparam int unsigned PW = (N_PARAM > 1) ? $clog2(N_PARAM) : 1;
  localparam int unsigned CW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;
  localparam logic [PW-1:0] LAST_P = PW'(N_PARAM - 1);
  localparam logic [CW-1:0] LAST_C = CW'(PULSE_W - 1);
  localparam logic [2:0]    LAST_S = 3'(STEPS - 1);

  seq_state_e            state_q;
  logic [PW-1:0]         param_q;
  logic [2:0]            step_q;
  logic [CW-1:0]         pcnt_q;
  logic [INTERVAL_W-1:0] wait_q;
  logic                  err_q, safe_q, danger_q;
  logic [PASS_W-1:0]     pass_q;

  logic running, pair_step, vote_sel, sample;
  logic single_bad, pair_bad, sweep_end, sweep_clean;

  always_comb begin
    running     = (state_q == SEQ_RUN);
    pair_step   = step_is_pair(step_q);
    vote_sel    = vote_i[param_q];
    // verdict at last pulse cycle; a real trip voids it
    sample      = running && (pcnt_q == LAST_C) && !trip_i;
    single_bad  = sample && !pair_step && vote_sel;
    pair_bad    = sample && pair_step && !vote_sel;
    sweep_end   = sample && (step_q == LAST_S) && (param_q == LAST_P);
    sweep_clean = !(err_q || single_bad || pair_bad);
  end

  for (genvar p = 0; p < N_PARAM; p++) begin : g_force
    assign force_mask_o[3*p +: 3] =
      (running && (param_q == PW'(p))) ? step_mask(step_q) : 3'b000;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      param_q <= '0;
      step_q  <= '0;
      pcnt_q  <= '0;
      wait_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        SEQ_IDLE: begin
          if (wait_q == '0) begin
            state_q <= trip_i ? SEQ_HOLD : SEQ_RUN;
            param_q <= '0;
            step_q  <= '0;
            pcnt_q  <= '0;
            err_q   <= 1'b0;
          end else begin
            wait_q <= wait_q - 1'b1;
          end
        end
        SEQ_RUN: begin
          if (trip_i) begin
            state_q <= SEQ_HOLD;
          end else begin
            if (single_bad || pair_bad) err_q <= 1'b1;
            if (pcnt_q == LAST_C) begin
              pcnt_q <= '0;
              if (step_q == LAST_S) begin
                step_q <= '0;
                if (param_q == LAST_P) begin
                  state_q <= SEQ_IDLE;
                  wait_q  <= interval_i;
                end else begin
                  param_q <= param_q + 1'b1;
                end
              end else begin
                step_q <= step_q + 1'b1;
              end
            end else begin
              pcnt_q <= pcnt_q + 1'b1;
            end
          end
        end
        SEQ_HOLD: begin
          if (!trip_i) begin
            state_q <= SEQ_RUN;
            param_q <= '0;
            step_q  <= '0;
            pcnt_q  <= '0;
            err_q   <= 1'b0;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      safe_q   <= 1'b0;
      danger_q <= 1'b0;
      pass_q   <= '0;
    end else begin
      if (clr_i) begin
        safe_q   <= 1'b0;
        danger_q <= 1'b0;
      end else begin
        if (single_bad) safe_q   <= 1'b1;
        if (pair_bad)   danger_q <= 1'b1;
      end
      if (sweep_end && sweep_clean) pass_q <= pass_q + 1'b1;
    end
  end

  assign act_o         = running;
  assign safe_fail_o   = safe_q;
  assign danger_fail_o = danger_q;
  assign pass_cnt_o    = pass_q;
endmodule

// File: rtl/trip_vote_fit.sv
module trip_vote_fit #(
  parameter int unsigned N_PARAM    = 4,
  parameter int unsigned PULSE_W    = 4,
  parameter int unsigned INTERVAL_W = 16,
  parameter int unsigned PASS_W     = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [3*N_PARAM-1:0]    chan_i,
  input  logic [INTERVAL_W-1:0]   interval_i,
  input  logic                    clr_i,
  output logic                    hold_o,
  output logic                    test_trip_o,
  output logic                    test_act_o,
  output logic                    safe_fail_o,
  output logic                    danger_fail_o,
  output logic [PASS_W-1:0]       pass_cnt_o
);
  localparam int unsigned CH = 3 * N_PARAM;

  logic [N_PARAM-1:0] real_vote, test_vote, test_vote_q;
  logic [CH-1:0]      force_mask, forced_chan;
  logic               trip_q;

  // forcing pulls channels to the trip level on the test copy only
  assign forced_chan = chan_i & ~force_mask;

  tvf_vote_bank #(.N_PARAM(N_PARAM)) u_real_vote (
    .chan_i (chan_i),
    .vote_o (real_vote)
  );

  tvf_vote_bank #(.N_PARAM(N_PARAM)) u_test_vote (
    .chan_i (forced_chan),
    .vote_o (test_vote)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q      <= 1'b1;
      test_vote_q <= '0;
    end else begin
      trip_q      <= |real_vote;
      test_vote_q <= test_vote;
    end
  end

  tvf_seq #(
    .N_PARAM    (N_PARAM),
    .PULSE_W    (PULSE_W),
    .INTERVAL_W (INTERVAL_W),
    .PASS_W     (PASS_W)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .interval_i    (interval_i),
    .clr_i         (clr_i),
    .trip_i        (trip_q),
    .vote_i        (test_vote_q),
    .force_mask_o  (force_mask),
    .act_o         (test_act_o),
    .safe_fail_o   (safe_fail_o),
    .danger_fail_o (danger_fail_o),
    .pass_cnt_o    (pass_cnt_o)
  );

  assign hold_o      = ~trip_q;
  assign test_trip_o = |test_vote_q;
endmodule

// File: rtl/trip_vote_fit_chk.sv
module trip_vote_fit_chk #(
  parameter int unsigned N_PARAM    = 4,
  parameter int unsigned INTERVAL_W = 16,
  parameter int unsigned PASS_W     = 16
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [3*N_PARAM-1:0]  chan_i,
  input logic [INTERVAL_W-1:0] interval_i,
  input logic                  clr_i,
  input logic                  hold_o,
  input logic                  test_trip_o,
  input logic                  test_act_o,
  input logic                  safe_fail_o,
  input logic                  danger_fail_o,
  input logic [PASS_W-1:0]     pass_cnt_o
);
  function automatic logic any_trip(input logic [3*N_PARAM-1:0] c);
    for (int p = 0; p < N_PARAM; p++) begin
      if ((32'(!c[3*p]) + 32'(!c[3*p+1]) + 32'(!c[3*p+2])) >= 2) return 1'b1;
    end
    return 1'b0;
  endfunction

  logic cur_trip;
  assign cur_trip = any_trip(chan_i);

  AST_HOLD_TRACKS_VOTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (hold_o == !$past(cur_trip))); // R2

  AST_IDLE_NO_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_act_o |=> (test_trip_o == $past(cur_trip))); // R5

  AST_SAFE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (safe_fail_o && !clr_i) |=> safe_fail_o); // R8

  AST_DANGER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (danger_fail_o && !clr_i) |=> danger_fail_o); // R8

  AST_FLAG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!safe_fail_o && !danger_fail_o)); // R8

  AST_SAFE_FROM_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(safe_fail_o) |-> $past(test_act_o)); // R6

  AST_DANGER_FROM_TEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(danger_fail_o) |-> $past(test_act_o)); // R7

  AST_PASS_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(pass_cnt_o) |-> (pass_cnt_o == $past(pass_cnt_o) + 1'b1)); // R9

  AST_TRIP_ABORTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o |=> !test_act_o); // R10
endmodule

bind trip_vote_fit trip_vote_fit_chk #(
  .N_PARAM    (N_PARAM),
  .INTERVAL_W (INTERVAL_W),
  .PASS_W     (PASS_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .chan_i        (chan_i),
  .interval_i    (interval_i),
  .clr_i         (clr_i),
  .hold_o        (hold_o),
  .test_trip_o   (test_trip_o),
  .test_act_o    (test_act_o),
  .safe_fail_o   (safe_fail_o),
  .danger_fail_o (danger_fail_o),
  .pass_cnt_o    (pass_cnt_o)
);

// File: tb/tb_trip_vote_fit.sv
module tb_trip_vote_fit;
  localparam int N     = 4;
  localparam int PLS   = 4;
  localparam int IW    = 16;
  localparam int PCW   = 16;
  localparam int CH    = 3 * N;
  localparam int SWEEP = N * 6 * PLS;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic [CH-1:0]  chan = '1;
  logic [IW-1:0]  interval = 16'd20;
  logic           clr = 1'b0;
  logic           hold_o, test_trip_o, test_act_o, safe_fail_o, danger_fail_o;
  logic [PCW-1:0] pass_cnt_o;

  int   n_cmp = 0;
  int   n_bad = 0;
  logic live = 1'b0;
  logic act_prev = 1'b0;
  int   len;
  int   base_pass;

  always #4 clk = ~clk;

  trip_vote_fit #(.N_PARAM(N), .PULSE_W(PLS), .INTERVAL_W(IW), .PASS_W(PCW)) dut (
    .clk_i (clk), .rst_ni (rst_ni), .chan_i (chan), .interval_i (interval),
    .clr_i (clr), .hold_o (hold_o), .test_trip_o (test_trip_o),
    .test_act_o (test_act_o), .safe_fail_o (safe_fail_o),
    .danger_fail_o (danger_fail_o), .pass_cnt_o (pass_cnt_o)
  );

  // R1 model: two or more low channels in a parameter trip it
  function automatic logic any_trip(input logic [CH-1:0] c);
    for (int p = 0; p < N; p++) begin
      if ((int'(!c[3*p]) + int'(!c[3*p+1]) + int'(!c[3*p+2])) >= 2) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle; per-cycle checks of R1/R2/R3 and R5
  task automatic tick();
    @(negedge clk);
    if (live) begin
      chk("R2 hold vs vote", int'(hold_o), int'(!any_trip(chan)));
      if (!act_prev) chk("R5 idle monitor", int'(test_trip_o), int'(any_trip(chan)));
    end
    act_prev = test_act_o;
  endtask

  task automatic wait_act(input logic v);
    while (test_act_o !== v) tick();
  endtask

  // counts negedges with test_act_o == v starting now
  task automatic run_len(input logic v, output int n);
    n = 0;
    while (test_act_o === v) begin
      n++;
      tick();
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL R4 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5e));
    repeat (3) tick();
    chk("R2 reset hold", int'(hold_o), 0);
    chk("R4 reset act", int'(test_act_o), 0);
    chk("R6 reset safe", int'(safe_fail_o), 0);
    chk("R7 reset danger", int'(danger_fail_o), 0);
    chk("R9 reset pass", int'(pass_cnt_o), 0);
    rst_ni = 1'b1;
    live   = 1'b1;

    // clean sweeps: length, gap, pass count, hold stays up (R3)
    wait_act(1'b1);
    run_len(1'b1, len);
    chk("R4 sweep length", len, SWEEP);
    chk("R9 clean pass", int'(pass_cnt_o), 1);
    chk("R6 clean safe", int'(safe_fail_o), 0);
    chk("R7 clean danger", int'(danger_fail_o), 0);
    run_len(1'b0, len);
    chk("R11 gap 20", len, 21);
    interval = 16'd37;
    run_len(1'b1, len);
    chk("R4 sweep length 2", len, SWEEP);
    chk("R9 clean pass 2", int'(pass_cnt_o), 2);

    // one real channel low on parameter 2: safe failure, output stays up
    chan[7] = 1'b0;
    run_len(1'b0, len);
    chk("R11 gap 37", len, 38);
    run_len(1'b1, len);
    chk("R4 sweep with low channel", len, SWEEP);
    chk("R6 safe set", int'(safe_fail_o), 1);
    chk("R7 danger clear", int'(danger_fail_o), 0);
    chk("R9 no pass on fault", int'(pass_cnt_o), 2);
    chk("R3 hold up with one low", int'(hold_o), 1);
    chan = '1;
    repeat (3) tick();
    chk("R8 safe sticky", int'(safe_fail_o), 1);
    clr = 1'b1;
    tick();
    clr = 1'b0;
    chk("R8 clear", int'(safe_fail_o), 0);
    wait_act(1'b1);
    run_len(1'b1, len);
    chk("R4 sweep after clear", len, SWEEP);
    chk("R9 pass after clear", int'(pass_cnt_o), 3);

    // genuine trip mid-sweep: abort, hold, restart from the top
    wait_act(1'b1);
    repeat (30) tick();
    chan[1:0] = 2'b00;
    tick();
    tick();
    chk("R10 aborted", int'(test_act_o), 0);
    repeat (40) tick();
    chk("R10 held off", int'(test_act_o), 0);
    chan = '1;
    tick();
    chk("R10 not yet", int'(test_act_o), 0);
    tick();
    chk("R10 restart", int'(test_act_o), 1);
    run_len(1'b1, len);
    chk("R10 full restart sweep", len, SWEEP);
    chk("R9 aborted not counted", int'(pass_cnt_o), 4);
    chk("R6 abort no safe", int'(safe_fail_o), 0);
    chk("R7 abort no danger", int'(danger_fail_o), 0);

    // random channel patterns with per-cycle hold/monitor checks
    interval = 16'd5;
    for (int i = 0; i < 400; i++) begin
      for (int p = 0; p < N; p++) begin
        int r;
        r = int'($urandom % 100);
        if (r < 80)      chan[3*p +: 3] = 3'b111;
        else if (r < 92) chan[3*p +: 3] = ~(3'b001 << ($urandom % 3));
        else             chan[3*p +: 3] = 3'b001 << ($urandom % 3);
      end
      repeat (1 + int'($urandom % 12)) tick();
    end
    chk("R7 random danger", int'(danger_fail_o), 0);
    chan = '1;
    clr  = 1'b1;
    tick();
    clr  = 1'b0;
    chk("R8 final clear safe", int'(safe_fail_o), 0);
    chk("R8 final clear danger", int'(danger_fail_o), 0);
    wait_act(1'b0);
    wait_act(1'b1);
    base_pass = int'(pass_cnt_o);
    run_len(1'b1, len);
    chk("R9 final clean sweep", int'(pass_cnt_o), base_pass + 1);

    summary();
    $finish;
  end
endmodule